// File: doc/BRIEF.md
# Wormhole Mesh Router with Central Switch Control

This block is a five-port router for a two-dimensional mesh network-on-chip. It has one port to the local processing element and one port each to the east, west, north and south neighbours. Every input port writes its incoming flits into a small FIFO. A single central controller looks at the FIFOs whose head flit is the header of a new packet and picks one of them with a rotating-priority arbiter. It computes the output direction from the header's destination coordinates, X first and then Y, and reserves that output for the input when the output is free. When the output is taken, the header is refused and stays where it is, together with every flit behind it. It is tried again on a later arbitration turn.

When a connection is in place, flits go from the input FIFO to the output register one per cycle, as long as the downstream port has credit. The second flit of each packet gives the number of payload flits that follow. A counter for each input uses it to find the tail, and the output is released in the cycle the tail leaves. Flow control is credit based in both directions. Each flit taken from an input FIFO returns a one-cycle credit pulse upstream. Each output spends one credit per flit and gains one back for each credit pulse from downstream.

Top module: `wr_router`

## Requirements
- R1: Once reset has been applied, every `out_valid` and every `in_credit` bit is low, and they stay low until a flit arrives.
- R2: Port indices are 0 local, 1 east, 2 west, 3 north, 4 south. A header flit carries the destination X in bits [7:4] and the destination Y in bits [3:0]. X is resolved first: east if the destination X is greater than the router's X, west if it is smaller. Only when X is equal is Y used: north if the destination Y is greater, south if it is smaller.
- R3: A header whose destination equals the router's own coordinates leaves on the local port.
- R4: A packet is a header, then a length flit whose bits [5:0] give N (0 to 46), then N payload flits. The whole packet of N+2 flits leaves on one output, in order, unmodified and contiguous.
- R5: A packet whose output is reserved by another packet is held in its input until the tail of the current packet has left. The two packets never interleave.
- R6: Requests are granted round-robin. The search starts at the input after the one granted last. After reset, input 0 has the highest priority.
- R7: Only one routing decision is made at a time, and each takes two cycles. Two headers that reach free, distinct outputs in the same cycle leave exactly two cycles apart.
- R8: An output holds OUT_CREDITS (4) credits. It stops sending when they are spent and resumes as credit pulses come back on `out_credit`.
- R9: Every flit taken from an input FIFO produces exactly one `in_credit` pulse on that port, so all credits an upstream sender spent are eventually returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Flit present on each input port |
| in_data | input | 5x16 | Flit data per input port |
| in_credit | output | 5 | One pulse per flit freed from each input FIFO |
| out_valid | output | 5 | Flit present on each output port |
| out_data | output | 5x16 | Flit data per output port |
| out_credit | input | 5 | Credit pulse returned by the downstream receiver |

## Verification
Two functions can land in the same cycle: releasing an output when a tail flit leaves, and a routing decision for a header that is waiting for that same output. The bench provokes this by sending a second packet toward an output while a long packet still holds it. The waiting header is refused over and over until the tail passes. The scoreboard then requires the second packet to appear whole, only after the first packet's last flit. Arbitration order and decision latency are judged by putting two headers into the FIFOs in the same cycle and measuring the cycle gap between their arrivals at their outputs.

// File: rtl/wr_pkg.sv
// Shared constants and the XY routing function for the mesh router.
// Assumes a 2D mesh without wrap-around; coordinates are unsigned.
package wr_pkg;
    localparam int NPORT   = 5;
    localparam int SEL_W   = 3;
    localparam int COORD_W = 4;
    localparam int LEN_W   = 6;

    localparam logic [SEL_W-1:0] P_LOCAL = 3'd0;
    localparam logic [SEL_W-1:0] P_EAST  = 3'd1;
    localparam logic [SEL_W-1:0] P_WEST  = 3'd2;
    localparam logic [SEL_W-1:0] P_NORTH = 3'd3;
    localparam logic [SEL_W-1:0] P_SOUTH = 3'd4;

    // Pick the output port: X offset is resolved before the Y offset.
    function automatic logic [SEL_W-1:0] xy_route(
        input logic [COORD_W-1:0] dst_x, input logic [COORD_W-1:0] dst_y,
        input logic [COORD_W-1:0] own_x, input logic [COORD_W-1:0] own_y);
        if (dst_x > own_x)      return P_EAST;
        else if (dst_x < own_x) return P_WEST;
        else if (dst_y > own_y) return P_NORTH;
        else if (dst_y < own_y) return P_SOUTH;
        else                    return P_LOCAL;
    endfunction
endpackage

// File: rtl/wr_fifo.sv
// Input flit buffer: single-clock FIFO with first-word-fall-through output.
// Assumes DEPTH is a power of two and the writer never writes when full.
module wr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    input  logic         rd_en,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign dout  = mem[rp];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    // R9
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R9
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/wr_rr_arbiter.sv
// Round-robin arbiter: the search starts after the last granted requester.
// Assumes the pointer only advances when 'en' is high and some request exists.
module wr_rr_arbiter #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last;

    // Find the first requester after the last granted one.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end

    // Remember the winner so it gets lowest priority next time.
    always_ff @(posedge clk) begin
        if (!rst_n)          last <= IW'(N-1);
        else if (en && |req) last <= gnt_idx;
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/wr_pkt_counter.sv
// Per-input packet tracker: follows header, length and payload flits and
// flags the pop that removes the tail. Assumes 'start' marks a new connection.
module wr_pkt_counter #(
    parameter int W       = 16,
    parameter int MAX_PKT = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         pop,
    input  logic [W-1:0] flit,
    output logic         tail
);
    import wr_pkg::*;

    typedef enum logic [1:0] {PH_HDR, PH_LEN, PH_BODY} phase_e;
    phase_e            ph;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  len_f;

    assign len_f = flit[LEN_W-1:0];
    assign tail  = pop && ((ph == PH_LEN && len_f == '0) ||
                           (ph == PH_BODY && rem == LEN_W'(1)));

    // Step through the packet one popped flit at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_HDR;
            rem <= '0;
        end else if (start) begin
            ph  <= PH_HDR;
        end else if (pop) begin
            case (ph)
                PH_HDR:  ph <= PH_LEN;
                PH_LEN:  begin rem <= len_f; ph <= (len_f == '0) ? PH_HDR : PH_BODY; end
                default: begin rem <= rem - 1'b1; if (rem == LEN_W'(1)) ph <= PH_HDR; end
            endcase
        end
    end

    // R4
    pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && ph == PH_LEN) |-> (int'(len_f) <= MAX_PKT - 2));
endmodule

// File: rtl/wr_router.sv
// Five-port wormhole mesh router with one central switch controller.
// Assumes upstream senders obey in_credit and the mesh has no wrap-around.
module wr_router #(
    parameter int FLIT_W      = 16,
    parameter int DEPTH       = 8,
    parameter int OUT_CREDITS = 4,
    parameter int MAX_PKT     = 48,
    parameter int MY_X        = 1,
    parameter int MY_Y        = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [wr_pkg::NPORT-1:0]               in_valid,
    input  logic [wr_pkg::NPORT-1:0][FLIT_W-1:0]   in_data,
    output logic [wr_pkg::NPORT-1:0]               in_credit,
    output logic [wr_pkg::NPORT-1:0]               out_valid,
    output logic [wr_pkg::NPORT-1:0][FLIT_W-1:0]   out_data,
    input  logic [wr_pkg::NPORT-1:0]               out_credit
);
    import wr_pkg::*;

    localparam int CW = $clog2(OUT_CREDITS + 1);
    localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

    typedef enum logic {ST_IDLE, ST_ROUTE} ctl_e;

    logic [FLIT_W-1:0] head [NPORT];
    logic [NPORT-1:0]  f_empty, f_full, pop, tail, req, gnt, send;
    logic              conn_v   [NPORT];
    logic [SEL_W-1:0]  conn_o   [NPORT];
    logic              out_busy [NPORT];
    logic [SEL_W-1:0]  out_own  [NPORT];
    logic [CW-1:0]     cred     [NPORT];
    ctl_e              state;
    logic [SEL_W-1:0]  sel, gnt_idx, dir;
    logic              accept;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        wr_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .wr_en(in_valid[i]), .din(in_data[i]),
            .rd_en(pop[i]), .dout(head[i]), .empty(f_empty[i]), .full(f_full[i]));

        wr_pkt_counter #(.W(FLIT_W), .MAX_PKT(MAX_PKT)) u_cnt (
            .clk(clk), .rst_n(rst_n), .start(accept && sel == SEL_W'(i)),
            .pop(pop[i]), .flit(head[i]), .tail(tail[i]));

        // A waiting header asks for a decision only while the controller is idle.
        assign req[i] = !f_empty[i] && !conn_v[i] && state == ST_IDLE;
        // A connected input forwards whenever it has data and its output has credit.
        assign pop[i] = conn_v[i] && !f_empty[i] && cred[conn_o[i]] != '0;
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // An output sends exactly when its owner pops.
        assign send[o] = out_busy[o] && pop[out_own[o]];
    end

    wr_rr_arbiter #(.N(NPORT), .IW(SEL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(state == ST_IDLE), .req(req),
        .gnt(gnt), .gnt_idx(gnt_idx));

    // Route the header held by the selected input and test its output.
    assign dir    = xy_route(head[sel][7:4], head[sel][3:0], OWN_X, OWN_Y);
    assign accept = (state == ST_ROUTE) && !out_busy[dir];

    // Controller sequencing, connection table, credits and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel       <= '0;
            in_credit <= '0;
            out_valid <= '0;
            for (int p = 0; p < NPORT; p++) begin
                conn_v[p]   <= 1'b0;
                conn_o[p]   <= '0;
                out_busy[p] <= 1'b0;
                out_own[p]  <= '0;
                cred[p]     <= CW'(OUT_CREDITS);
                out_data[p] <= '0;
            end
        end else begin
            if (state == ST_IDLE) begin
                if (|req) begin
                    state <= ST_ROUTE;
                    sel   <= gnt_idx;
                end
            end else begin
                state <= ST_IDLE;
            end
            for (int p = 0; p < NPORT; p++) begin
                if (pop[p] && tail[p])          conn_v[p]   <= 1'b0;
                if (send[p] && tail[out_own[p]]) out_busy[p] <= 1'b0;
                cred[p]     <= cred[p] - CW'(send[p]) + CW'(out_credit[p]);
                out_data[p] <= head[out_own[p]];
            end
            if (accept) begin
                conn_v[sel]   <= 1'b1;
                conn_o[sel]   <= dir;
                out_busy[dir] <= 1'b1;
                out_own[dir]  <= sel;
            end
            out_valid <= send;
            in_credit <= pop;
        end
    end

    for (genvar k = 0; k < NPORT; k++) begin : g_chk
        // R8
        credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cred[k] <= CW'(OUT_CREDITS));
        // R5
        owner_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conn_v[k] |-> (out_busy[conn_o[k]] && out_own[conn_o[k]] == SEL_W'(k)));
    end

    // R7
    decision_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && |req) |=> (state == ST_ROUTE));
    // R5
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROUTE && out_busy[dir]) |=> !conn_v[$past(sel)]);
endmodule

// File: tb/wr_router_bench.sv
// Scoreboard bench: enqueue tasks fill per-port source and expected queues,
// a driver process feeds flits under credit, a monitor compares arrivals.
module wr_router_bench;
    localparam int NP   = 5;
    localparam int FW   = 16;
    localparam int DEP  = 8;
    localparam int OCR  = 4;
    localparam int MX   = 1;
    localparam int MY   = 1;
    localparam int LIM  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]          in_valid = '0;
    logic [NP-1:0][FW-1:0]  in_data  = '0;
    logic [NP-1:0]          in_credit;
    logic [NP-1:0]          out_valid;
    logic [NP-1:0][FW-1:0]  out_data;
    logic [NP-1:0]          out_credit = '0;

    wr_router #(.FLIT_W(FW), .DEPTH(DEP), .OUT_CREDITS(OCR), .MAX_PKT(48),
                .MY_X(MX), .MY_Y(MY)) u_wr_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_credit(in_credit), .out_valid(out_valid), .out_data(out_data),
        .out_credit(out_credit));

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [FW-1:0] src_q [NP][$];
    logic [FW:0]   exp_q [NP][$];
    int icred [NP];
    int owed  [NP];
    int rx_cnt[NP];
    int hdr_t [NP];
    bit hold  [NP];
    bit drive_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected output port, from the X-then-Y rule.
    function automatic int exp_port(input int dx, input int dy);
        if (dx > MX) return 1;
        if (dx < MX) return 2;
        if (dy > MY) return 3;
        if (dy < MY) return 4;
        return 0;
    endfunction

    // Queue one packet on input src and its expected flits on the output.
    task automatic send_pkt(input int src, input int dx, input int dy,
                            input int n, input logic [7:0] tag);
        int op;
        logic [FW-1:0] f;
        op = exp_port(dx, dy);
        f = {tag, 4'(dx), 4'(dy)};
        src_q[src].push_back(f); exp_q[op].push_back({1'b1, f});
        f = {tag, 2'b00, 6'(n)};
        src_q[src].push_back(f); exp_q[op].push_back({1'b0, f});
        for (int k = 0; k < n; k++) begin
            f = {tag, 8'(k + 1)};
            src_q[src].push_back(f); exp_q[op].push_back({1'b0, f});
        end
    endtask

    // Driver: one flit per port per cycle while upstream credit lasts.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (in_credit[p]) icred[p]++;
            in_valid[p] = 1'b0;
            if (drive_on && src_q[p].size() > 0 && icred[p] > 0) begin
                in_valid[p] = 1'b1;
                in_data[p]  = src_q[p].pop_front();
                icred[p]--;
            end
        end
    end

    // Monitor: compare each arriving flit, then return downstream credit.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (rst_n && out_valid[p]) begin
                logic [FW:0] e;
                rx_cnt[p]++;
                owed[p]++;
                if (exp_q[p].size() == 0) begin
                    chk(1'b0, "R4 unexpected flit", int'(out_data[p]), -1);
                end else begin
                    e = exp_q[p].pop_front();
                    // R2 R3 R4 R5: right port, right order, unmodified
                    chk(out_data[p] == e[FW-1:0], "R4 flit data/port",
                        int'(out_data[p]), int'(e[FW-1:0]));
                    if (e[FW]) hdr_t[p] = cyc;
                end
            end
            out_credit[p] = 1'b0;
            if (owed[p] > 0 && !hold[p]) begin
                out_credit[p] = 1'b1;
                owed[p]--;
            end
        end
    end

    task automatic drain(input string tag);
        int t = 0;
        bit busy = 1'b1;
        while (busy && t < 4000) begin
            busy = 1'b0;
            for (int p = 0; p < NP; p++)
                if (src_q[p].size() > 0 || exp_q[p].size() > 0) busy = 1'b1;
            @(negedge clk);
            t++;
        end
        chk(!busy, {tag, " drain"}, t, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int r0;
        for (int p = 0; p < NP; p++) begin
            icred[p] = DEP; owed[p] = 0; rx_cnt[p] = 0; hdr_t[p] = 0; hold[p] = 1'b0;
        end
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_credit == '0, "R1 in_credit in reset", int'(in_credit), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_credit == '0, "R1 in_credit after reset", int'(in_credit), 0);
        drive_on = 1'b1;

        // R2: local input to east
        send_pkt(0, 2, 1, 3, 8'h10);
        drain("R2 east");
        chk(rx_cnt[1] == 5, "R2 east flit count", rx_cnt[1], 5);

        // R2 R3: all five outputs at once, X resolved before Y, own address local
        send_pkt(0, 0, 1, 2, 8'h21);
        send_pkt(2, 1, 2, 1, 8'h22);
        send_pkt(4, 1, 0, 4, 8'h23);
        send_pkt(1, 1, 1, 3, 8'h24);
        send_pkt(3, 2, 0, 2, 8'h25);
        drain("R2 parallel");
        chk(rx_cnt[0] == 5, "R3 local flit count", rx_cnt[0], 5);
        chk(rx_cnt[1] == 9, "R2 X-before-Y east count", rx_cnt[1], 9);

        // R4 R9: shortest and longest packets through one input
        send_pkt(2, 3, 3, 0, 8'h30);
        send_pkt(2, 3, 3, 46, 8'h31);
        drain("R4 lengths");
        chk(rx_cnt[1] == 9 + 2 + 48, "R4 long packet count", rx_cnt[1], 59);

        // R5: second packet to a busy output waits for the first tail
        r0 = rx_cnt[1];
        send_pkt(1, 2, 1, 20, 8'h40);
        while (rx_cnt[1] == r0) @(negedge clk);
        send_pkt(3, 2, 2, 2, 8'h41);
        drain("R5 blocking");
        chk(rx_cnt[1] - r0 == 26, "R5 both packets whole", rx_cnt[1] - r0, 26);

        // R6 R7: last grant was input 3, so input 4 beats input 2
        @(negedge clk);
        send_pkt(2, 0, 1, 0, 8'h50);
        send_pkt(4, 1, 2, 0, 8'h51);
        drain("R6 first pair");
        chk(hdr_t[2] - hdr_t[3] == 2, "R6 R7 input4 before input2 by 2",
            hdr_t[2] - hdr_t[3], 2);
        // R6: last grant now input 2, so input 3 beats input 1
        send_pkt(1, 1, 0, 0, 8'h52);
        send_pkt(3, 2, 1, 0, 8'h53);
        drain("R6 second pair");
        chk(hdr_t[4] - hdr_t[1] == 2, "R6 R7 input3 before input1 by 2",
            hdr_t[4] - hdr_t[1], 2);

        // R8: withheld downstream credit stops the output after OUT_CREDITS flits
        hold[1] = 1'b1;
        r0 = rx_cnt[1];
        send_pkt(0, 2, 1, 8, 8'h60);
        repeat (40) @(negedge clk);
        chk(rx_cnt[1] - r0 == OCR, "R8 stall at credit limit", rx_cnt[1] - r0, OCR);
        hold[1] = 1'b0;
        drain("R8 resume");
        chk(rx_cnt[1] - r0 == 10, "R8 remainder after credit", rx_cnt[1] - r0, 10);

        // R9: every upstream credit came back
        for (int p = 0; p < NP; p++)
            chk(icred[p] == DEP, "R9 input credits restored", icred[p], DEP);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= LIM);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIM);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule